// File: doc/BRIEF.md
# Interrupt Context Save and Restore Engine

This block carries out the hardware part of taking an interrupt and of returning from one, for a CPU with a 16-bit program counter, an 8-bit status word and a byte-wide stack that grows toward lower addresses. When the CPU pulses `entry_i`, the engine latches the current program counter and status word. It stores three bytes on the stack, acknowledges the interrupt, samples a vector index and reads the two-byte handler address from a vector table in memory. It then presents the new program counter, together with the status word with its interrupt-enable bit cleared.

When the CPU pulses `reti_i`, the engine reads the three bytes back in the reverse order and presents the restored program counter and status word. The stack pointer is held inside the engine, so nested entries and returns stack up without further bookkeeping. All memory traffic goes through one byte-wide port. Read data arrives one clock after the read strobe.

Top module: `irq_ctx_engine`

## Requirements
- R1: After reset, `sp_o` equals SP_INIT (default 0x00FF), and `busy_o`, `done_o`, `inta_o`, `mem_we_o` and `mem_re_o` are low, with `pc_o` and `psw_o` at zero.
- R2: Entry writes three bytes in three consecutive cycles. The first byte is PC[15:8] at SP-1, the second is PC[7:0] at SP-2 and the third is the PSW at SP-3. The SP is decremented before each write and ends 3 lower. The PC and PSW are the values sampled in the cycle `entry_i` is accepted.
- R3: The stored PSW byte is the value before any change. On entry, `psw_o` is that value with bit IE_BIT (default 7) forced to 0 and every other bit kept.
- R4: `inta_o` is high for exactly one cycle, which is the cycle after the third write. `vec_i` is sampled in that cycle and is ignored in every other cycle.
- R5: The handler address is read as a high byte at VT_BASE + 2*index and a low byte at VT_BASE + 2*index + 1 (default VT_BASE 0x0040). Each byte is taken from `mem_rdata_i` one cycle after its read strobe. `pc_o` becomes {high, low}.
- R6: Return reads the PSW at SP, then PC[7:0] at SP+1, then PC[15:8] at SP+2, in consecutive cycles. The SP is incremented after each read and ends 3 higher. `pc_o` and `psw_o` then show the restored values.
- R7: `done_o` is high for exactly one cycle, with `pc_o` and `psw_o` already valid. On entry this is the 8th cycle after the accepting clock edge. On return it is the 5th cycle after that edge.
- R8: `busy_o` is high from the cycle after acceptance through the `done_o` cycle. `entry_i` and `reti_i` have no effect while `busy_o` is high.
- R9: If `entry_i` and `reti_i` are both high while idle, the entry sequence runs and the return request is dropped.
- R10: Nested entries stack last-in first-out. Each return restores the PC and PSW of the most recent entry that has not yet been undone.
- R11: `mem_we_o` and `mem_re_o` are never high in the same cycle. `sp_o` does not change while the engine is idle and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_i | input | 1 | Interrupt entry request pulse |
| reti_i | input | 1 | Return-from-interrupt request pulse |
| pc_i | input | 16 | Current program counter, sampled on entry |
| psw_i | input | 8 | Current status word, sampled on entry |
| vec_i | input | VEC_W (4) | Vector index, sampled during acknowledge |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| mem_addr_o | output | AW (16) | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after read enable |
| pc_o | output | 16 | Program counter to load |
| psw_o | output | 8 | Status word to load |
| sp_o | output | AW (16) | Stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A wrong state in the sequencer is visible at the memory port within one cycle, as a missing, extra or reordered strobe. It also moves the `inta_o` or `done_o` pulse away from its fixed cycle. A corrupted stack pointer may not show on entry, but it shows at the next return, where the wrong bytes come back to `pc_o`/`psw_o`. Nested random sequences followed by a full unwind catch such drift after only a few operations. A wrong vector latch cycle appears directly as a wrong handler address, because the bench changes `vec_i` in every cycle except the acknowledge cycle.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_PUSH_P,
    ST_ACK,
    ST_VT_H,
    ST_VT_L,
    ST_VT_W,
    ST_POP_P,
    ST_POP_L,
    ST_POP_H,
    ST_POP_W,
    ST_FIN
  } ctx_state_e;

  typedef enum logic [1:0] {
    SP_HOLD,
    SP_DEC,
    SP_INC
  } sp_op_e;

endpackage

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
  import irq_ctx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       entry_i,
  input  logic       reti_i,
  output ctx_state_e state_o,
  output sp_op_e     sp_op_o,
  output logic       start_o,
  output logic       busy_o,
  output logic       done_o
);

  ctx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        // entry has priority over a simultaneous return
        if (entry_i)     state_d = ST_PUSH_H;
        else if (reti_i) state_d = ST_POP_P;
      end
      ST_PUSH_H: state_d = ST_PUSH_L;
      ST_PUSH_L: state_d = ST_PUSH_P;
      ST_PUSH_P: state_d = ST_ACK;
      ST_ACK:    state_d = ST_VT_H;
      ST_VT_H:   state_d = ST_VT_L;
      ST_VT_L:   state_d = ST_VT_W;
      ST_VT_W:   state_d = ST_FIN;
      ST_POP_P:  state_d = ST_POP_L;
      ST_POP_L:  state_d = ST_POP_H;
      ST_POP_H:  state_d = ST_POP_W;
      ST_POP_W:  state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_PUSH_H, ST_PUSH_L, ST_PUSH_P: sp_op_o = SP_DEC;
      ST_POP_P, ST_POP_L, ST_POP_H:    sp_op_o = SP_INC;
      default:                         sp_op_o = SP_HOLD;
    endcase
  end

  assign state_o = state_q;
  assign start_o = (state_q == ST_IDLE) && entry_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_FIN);

endmodule

// File: rtl/irq_ctx_sp.sv
module irq_ctx_sp
  import irq_ctx_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned SP_INIT = 'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sp_op_e        op_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_dec_o
);

  localparam logic [AW-1:0] SpReset = AW'(SP_INIT);
  localparam logic [AW-1:0] SpOne   = AW'(1);

  logic [AW-1:0] sp_q;

  assign sp_dec_o = sp_q - SpOne;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= SpReset;
    end else begin
      unique case (op_i)
        SP_DEC:  sp_q <= sp_dec_o;
        SP_INC:  sp_q <= sp_q + SpOne;
        default: sp_q <= sp_q;
      endcase
    end
  end

  assign sp_o = sp_q;

endmodule

// File: rtl/irq_ctx_dp.sv
module irq_ctx_dp
  import irq_ctx_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 16,
  parameter int unsigned VEC_W   = 4,
  parameter int unsigned VT_BASE = 'h40,
  parameter int unsigned IE_BIT  = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctx_state_e      state_i,
  input  logic            start_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [DW-1:0]   psw_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [AW-1:0]   sp_dec_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic            inta_o,
  output logic [2*DW-1:0] pc_o,
  output logic [DW-1:0]   psw_o
);

  localparam int unsigned PC_W = 2 * DW;
  localparam logic [AW-1:0] VtBase = AW'(VT_BASE);
  localparam logic [DW-1:0] IeMask = DW'(1) << IE_BIT;

  logic [PC_W-1:0]  sv_pc_q;
  logic [DW-1:0]    sv_psw_q;
  logic [VEC_W-1:0] vec_q;
  logic [DW-1:0]    byte_q;
  logic [DW-1:0]    pop_psw_q;
  logic [AW-1:0]    vt_addr;

  assign vt_addr = VtBase + AW'({vec_q, 1'b0});

  // capture registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sv_pc_q   <= '0;
      sv_psw_q  <= '0;
      vec_q     <= '0;
      byte_q    <= '0;
      pop_psw_q <= '0;
      pc_o      <= '0;
      psw_o     <= '0;
    end else begin
      if (start_i) begin
        sv_pc_q  <= pc_i;
        sv_psw_q <= psw_i;
      end
      unique case (state_i)
        ST_ACK:   vec_q     <= vec_i;
        ST_VT_L:  byte_q    <= mem_rdata_i;
        ST_VT_W: begin
          pc_o  <= {byte_q, mem_rdata_i};
          psw_o <= sv_psw_q & ~IeMask;
        end
        ST_POP_L: pop_psw_q <= mem_rdata_i;
        ST_POP_H: byte_q    <= mem_rdata_i;
        ST_POP_W: begin
          pc_o  <= {mem_rdata_i, byte_q};
          psw_o <= pop_psw_q;
        end
        default: ;
      endcase
    end
  end

  // memory port decode
  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    inta_o      = 1'b0;
    unique case (state_i)
      ST_PUSH_H: begin
        mem_we_o = 1'b1; mem_addr_o = sp_dec_i; mem_wdata_o = sv_pc_q[PC_W-1:DW];
      end
      ST_PUSH_L: begin
        mem_we_o = 1'b1; mem_addr_o = sp_dec_i; mem_wdata_o = sv_pc_q[DW-1:0];
      end
      ST_PUSH_P: begin
        mem_we_o = 1'b1; mem_addr_o = sp_dec_i; mem_wdata_o = sv_psw_q;
      end
      ST_ACK:  inta_o = 1'b1;
      ST_VT_H: begin
        mem_re_o = 1'b1; mem_addr_o = vt_addr;
      end
      ST_VT_L: begin
        mem_re_o = 1'b1; mem_addr_o = vt_addr + AW'(1);
      end
      ST_POP_P, ST_POP_L, ST_POP_H: begin
        mem_re_o = 1'b1; mem_addr_o = sp_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_ctx_engine.sv
module irq_ctx_engine
  import irq_ctx_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 16,
  parameter int unsigned VEC_W   = 4,
  parameter int unsigned VT_BASE = 'h40,
  parameter int unsigned SP_INIT = 'hFF,
  parameter int unsigned IE_BIT  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic             reti_i,
  input  logic [2*DW-1:0]  pc_i,
  input  logic [DW-1:0]    psw_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             inta_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [2*DW-1:0]  pc_o,
  output logic [DW-1:0]    psw_o,
  output logic [AW-1:0]    sp_o,
  output logic             busy_o,
  output logic             done_o
);

  ctx_state_e    state;
  sp_op_e        sp_op;
  logic          start;
  logic [AW-1:0] sp_dec;

  irq_ctx_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .entry_i (entry_i),
    .reti_i  (reti_i),
    .state_o (state),
    .sp_op_o (sp_op),
    .start_o (start),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  irq_ctx_sp #(
    .AW      (AW),
    .SP_INIT (SP_INIT)
  ) u_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (sp_op),
    .sp_o     (sp_o),
    .sp_dec_o (sp_dec)
  );

  irq_ctx_dp #(
    .DW      (DW),
    .AW      (AW),
    .VEC_W   (VEC_W),
    .VT_BASE (VT_BASE),
    .IE_BIT  (IE_BIT)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .start_i     (start),
    .pc_i        (pc_i),
    .psw_i       (psw_i),
    .vec_i       (vec_i),
    .sp_i        (sp_o),
    .sp_dec_i    (sp_dec),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .inta_o      (inta_o),
    .pc_o        (pc_o),
    .psw_o       (psw_o)
  );

endmodule

// File: rtl/irq_ctx_engine_chk.sv
module irq_ctx_engine_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          entry_i,
  input logic          reti_i,
  input logic          inta_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] sp_o,
  input logic          busy_o,
  input logic          done_o
);

  p_single_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  p_push_predec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(sp_o) - AW'(1));

  p_pop_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (sp_o == $past(sp_o) + AW'(1)) || $stable(sp_o));

  p_inta_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> !inta_o);

  p_inta_after_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inta_o) |-> $past(mem_we_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  p_sp_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !entry_i && !reti_i) |=> $stable(sp_o));

endmodule

bind irq_ctx_engine irq_ctx_engine_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .entry_i  (entry_i),
  .reti_i   (reti_i),
  .inta_o   (inta_o),
  .mem_we_o (mem_we_o),
  .mem_re_o (mem_re_o),
  .sp_o     (sp_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/irq_ctx_engine_tb.sv
`timescale 1ns/1ps
module irq_ctx_engine_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        entry_i = 1'b0;
  logic        reti_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  psw_i = '0;
  logic [3:0]  vec_i = '0;
  logic        inta_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_we_o;
  logic        mem_re_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [15:0] pc_o;
  logic [7:0]  psw_o;
  logic [15:0] sp_o;
  logic        busy_o;
  logic        done_o;

  always #2 clk_i = ~clk_i;

  irq_ctx_engine u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .entry_i (entry_i), .reti_i (reti_i),
    .pc_i (pc_i), .psw_i (psw_i), .vec_i (vec_i), .inta_o (inta_o),
    .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o), .mem_we_o (mem_we_o),
    .mem_re_o (mem_re_o), .mem_rdata_i (mem_rdata_i), .pc_o (pc_o), .psw_o (psw_o),
    .sp_o (sp_o), .busy_o (busy_o), .done_o (done_o)
  );

  int n_checks = 0;
  int n_err = 0;
  int both_cnt = 0;
  int off_page = 0;
  bit finished = 0;

  logic [7:0]  mem [0:255];
  logic [15:0] vt_exp [0:15];
  logic [15:0] exp_sp;
  logic [15:0] pc_stk [0:15];
  logic [7:0]  psw_stk [0:15];
  int          depth = 0;

  // bench memory: one-cycle read latency, table loaded during reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      for (int v = 0; v < 16; v++) begin
        mem[64 + 2*v] <= vt_exp[v][15:8];
        mem[65 + 2*v] <= vt_exp[v][7:0];
      end
    end else begin
      if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
      if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
      if (mem_we_o && mem_re_o) both_cnt++;
      if ((mem_we_o || mem_re_o) && mem_addr_o[15:8] != 8'h00) off_page++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clr_ie(input logic [7:0] p);
    return p & 8'h7F;
  endfunction

  task automatic do_entry(input logic [15:0] pc, input logic [7:0] psw, input logic [3:0] vec,
                          input bit with_reti, input bit inject);
    logic [15:0] sp0 = exp_sp;
    int done_at = -1, n_done = 0, inta_at = -1, n_inta = 0, busy0 = 0;
    logic [15:0] pc_got = '0;
    logic [7:0]  psw_got = '0;
    @(negedge clk_i);
    entry_i = 1'b1; reti_i = with_reti; pc_i = pc; psw_i = psw; vec_i = vec ^ 4'hF;
    @(negedge clk_i);
    entry_i = 1'b0; reti_i = 1'b0; pc_i = 16'($urandom); psw_i = 8'($urandom);
    for (int k = 0; k < 12; k++) begin
      if (k == 0) busy0 = busy_o;
      if (inta_o) begin n_inta++; inta_at = k; end
      if (done_o) begin n_done++; done_at = k; pc_got = pc_o; psw_got = psw_o; end
      vec_i = (k == 3) ? vec : (vec ^ 4'hF);
      if (inject && k == 2) begin entry_i = 1'b1; reti_i = 1'b1; end
      else begin entry_i = 1'b0; reti_i = 1'b0; end
      @(negedge clk_i);
    end
    check("R8 busy after accept", busy0, 1);
    check("R8 idle after done", busy_o, 0);
    check("R7 entry done cycle", done_at, 7);
    check("R7 entry done count", n_done, 1);
    check("R4 inta cycle", inta_at, 3);
    check("R4 inta count", n_inta, 1);
    check("R5 handler pc", pc_got, vt_exp[vec]);
    check("R3 psw IE cleared", psw_got, clr_ie(psw));
    check("R2 pc high byte", mem[8'(sp0 - 16'd1)], pc[15:8]);
    check("R2 pc low byte", mem[8'(sp0 - 16'd2)], pc[7:0]);
    check("R3 stored psw unmodified", mem[8'(sp0 - 16'd3)], psw);
    exp_sp = sp0 - 16'd3;
    check("R2 sp after entry", sp_o, exp_sp);
    pc_stk[depth] = pc; psw_stk[depth] = psw; depth++;
  endtask

  task automatic do_reti(input bit inject);
    int done_at = -1, n_done = 0;
    logic [15:0] pc_got = '0;
    logic [7:0]  psw_got = '0;
    @(negedge clk_i);
    reti_i = 1'b1;
    @(negedge clk_i);
    reti_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (done_o) begin n_done++; done_at = k; pc_got = pc_o; psw_got = psw_o; end
      entry_i = (inject && k == 1);
      @(negedge clk_i);
    end
    entry_i = 1'b0;
    depth--;
    exp_sp = exp_sp + 16'd3;
    check("R7 reti done cycle", done_at, 4);
    check("R7 reti done count", n_done, 1);
    check("R6 restored pc", pc_got, pc_stk[depth]);
    check("R6 restored psw", psw_got, psw_stk[depth]);
    check("R6 sp after reti", sp_o, exp_sp);
    check("R8 idle after reti", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int v = 0; v < 16; v++) vt_exp[v] = 16'($urandom);
    vt_exp[3] = 16'h3000;
    vt_exp[5] = 16'h4000;
    exp_sp = 16'h00FF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 sp reset", sp_o, 16'h00FF);
    check("R1 busy reset", busy_o, 0);
    check("R1 done reset", done_o, 0);
    check("R1 strobes reset", {inta_o, mem_we_o, mem_re_o}, 0);
    check("R1 pc/psw reset", {pc_o, psw_o}, 0);
    // R11 idle stability
    repeat (4) @(negedge clk_i);
    check("R11 sp stable idle", sp_o, 16'h00FF);

    // directed nesting example (R10)
    do_entry(16'h15A4, 8'h80, 4'd3, 1'b0, 1'b0);
    do_entry(16'h3012, 8'h81, 4'd5, 1'b0, 1'b0);
    check("R10 nested sp", sp_o, 16'h00F9);
    do_reti(1'b0);
    check("R10 first return pc", pc_o, 16'h3012);
    do_reti(1'b0);
    check("R10 second return pc", pc_o, 16'h15A4);
    check("R10 unwound sp", sp_o, 16'h00FF);

    // R9 simultaneous request, R8 requests while busy
    do_entry(16'hBEEF, 8'hFF, 4'd15, 1'b1, 1'b1);
    do_reti(1'b1);
    check("R9 sp back to base", sp_o, 16'h00FF);

    // constrained random nesting
    for (int it = 0; it < 40; it++) begin
      if (depth == 0 || (depth < 6 && ($urandom % 2) == 0))
        do_entry(16'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
      else
        do_reti(1'($urandom));
    end
    while (depth > 0) do_reti(1'b0);
    check("R10 final sp", sp_o, 16'h00FF);
    check("R11 no concurrent access", both_cnt, 0);
    check("R5 addresses on page zero", off_page, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule